// File: doc/BRIEF.md
# Converter Fault Supervisor

This block decides whether a single-stage LED power converter may switch. It receives already-synchronized flags from external comparators and monitors: supply level against the turn-on and turn-off points, die temperature against a trip point and a lower release point, and three fast power-stage faults. The fast faults are excess current in the sense resistor, excess voltage on the auxiliary winding (overvoltage or an open output), and a pulse in which the sense voltage never reached its minimum level (open loop or a shorted sense resistor). It also receives an overpower flag for the dimmer-compatibility switch and the raw on/off state of the voltage clamp.

Faults fall into three recovery classes. Fast power-stage faults block the converter for a short retry wait (one second at the default tick). Switch overpower blocks it for a long retry wait (thirty seconds). A clamp whose averaged on-time exceeds ten percent latches a fault that turns off the converter and the clamp/dimmer circuit until the supply falls below its turn-off point. Die temperature and supply level release with hysteresis. A first-order filter averages the clamp on-time, and a prescaled millisecond tick drives the retry counters.

A 3-bit code reports the most serious active condition, so that control logic or a test port can tell why switching stopped.

Top module: `fault_supervisor`

## Requirements
- R1: After reset, or when `vddAboveOff` is low at a clock edge, the block is unpowered: `convEnable`=0, `clampEnable`=0, `faultCode`=1. It becomes powered at the first edge where `vddAboveOn` is high, and then stays powered while `vddAboveOff` stays high, even if `vddAboveOn` falls.
- R2: Dropping to the unpowered state clears the latched clamp fault, the retry waits and the clamp average. After power returns, the converter is enabled at once.
- R3: A high `ocpTrip`, `ovpTrip` or `olpTrip` at an edge sets `convEnable` to 0 and `faultCode` to 3 after that edge. The converter is enabled again SHORT_TICKS*TICK_DIV cycles after the last such edge.
- R4: A high `switchOverpower` at an edge sets `convEnable` to 0 and `faultCode` to 4. The converter is enabled again LONG_TICKS*TICK_DIV cycles after that edge.
- R5: A fault that arrives during a retry wait restarts the wait. The new wait has the length of the longer of the class already waiting and the class that just arrived, so a fast fault during a long wait restarts the full long wait.
- R6: When the clamp on-time average (a first-order filter with a 2^AVG_SHIFT-cycle time constant on a full-scale value of 2^AVG_W-1) exceeds LIMIT_PCT percent of full scale, `convEnable` and `clampEnable` both go to 0 and `faultCode` becomes 5. This state holds while the supply stays above the turn-off point.
- R7: Clamp activity with a duty well below the limit (5 % or 8 % at the default 10 %) never latches the fault.
- R8: A high `dieAboveTrip` at an edge sets `convEnable` to 0 and `faultCode` to 2. The condition holds until an edge with `dieBelowRelease` high and `dieAboveTrip` low.
- R9: `faultCode` reports a single cause in this order of precedence: unpowered 1, then latched clamp 5, then long wait 4, then short wait 3, then thermal 2. It reads 0 when nothing is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset, same effect as supply loss |
| vddAboveOn | input | 1 | Supply is above the turn-on point |
| vddAboveOff | input | 1 | Supply is above the turn-off point |
| dieAboveTrip | input | 1 | Die temperature is above the shutdown point |
| dieBelowRelease | input | 1 | Die temperature is below the release point |
| ocpTrip | input | 1 | Sense voltage exceeded the overcurrent level |
| ovpTrip | input | 1 | Auxiliary winding exceeded the overvoltage level |
| olpTrip | input | 1 | Pulse ended without the sense reaching its minimum |
| switchOverpower | input | 1 | Dimmer-compatibility switch dissipation too high |
| clampActive | input | 1 | Voltage clamp is conducting this cycle |
| convEnable | output | 1 | Converter may switch |
| clampEnable | output | 1 | Clamp and dimmer-compatibility circuit may operate |
| faultCode | output | 3 | Cause code, see R9 |

## Verification
The hardest state to reach from the ports is the latched clamp fault. The filter responds only to the average of clamp activity, so a single pulse does nothing, and a duty just under the limit must show that ripple never crosses the threshold. The stimulus drives long periodic clamp trains at 5 %, 8 % and 20 % duty and checks that only the last one latches. It then stacks an overpower fault and a supply cycle on top of the latch, to show precedence and release. Waits that overlap (a fast fault inside a long wait) are timed from the second fault's edge, and the bench samples a few cycles on each side of the expected release.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_SHORT = 2'd1,
    CLS_LONG  = 2'd2
  } retryClass_t;

  typedef struct packed {
    logic clearAll;
    logic loadShort;
    logic loadLong;
  } dpStrobe_t;

  localparam logic [2:0] CODE_NONE    = 3'd0;
  localparam logic [2:0] CODE_UNPOWER = 3'd1;
  localparam logic [2:0] CODE_THERMAL = 3'd2;
  localparam logic [2:0] CODE_SHORT   = 3'd3;
  localparam logic [2:0] CODE_LONG    = 3'd4;
  localparam logic [2:0] CODE_LATCH   = 3'd5;

endpackage

// File: rtl/fsup_datapath.sv
module fsup_datapath
  import fsup_pkg::*;
#(
  parameter int TICK_DIV    = 100000,
  parameter int SHORT_TICKS = 1000,
  parameter int LONG_TICKS  = 30000,
  parameter int AVG_W       = 8,
  parameter int AVG_SHIFT   = 8,
  parameter int LIMIT_PCT   = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  input  logic      clampActive,
  output logic      timerIdle,
  output logic      clampOver
);

  localparam int PRE_W   = $clog2(TICK_DIV + 1);
  localparam int TMR_W   = $clog2(LONG_TICKS + 1);
  localparam int ACC_W   = AVG_W + AVG_SHIFT;
  localparam int FULL    = (1 << AVG_W) - 1;
  localparam int LIMIT   = (FULL * LIMIT_PCT) / 100;
  localparam int ACC_MAX = FULL << AVG_SHIFT;

  logic             tick;
  logic [TMR_W-1:0] timer;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accNext;
  logic             anyLoad;

  assign anyLoad = strobe.loadShort | strobe.loadLong;

  // millisecond prescaler, restarted on every load so each wait is exact
  generate
    if (TICK_DIV <= 1) begin : g_noPrescale
      assign tick = 1'b1;
    end else begin : g_prescale
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          preCnt <= '0;
        end else if (strobe.clearAll || anyLoad || preCnt == PRE_W'(TICK_DIV - 1)) begin
          preCnt <= '0;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
      assign tick = (preCnt == PRE_W'(TICK_DIV - 1));
    end
  endgenerate

  // restart wait counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strobe.clearAll) begin
      timer <= '0;
    end else if (strobe.loadLong) begin
      timer <= TMR_W'(LONG_TICKS);
    end else if (strobe.loadShort) begin
      timer <= TMR_W'(SHORT_TICKS);
    end else if (tick && timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  assign timerIdle = (timer == '0);

  // first-order average of clamp on-time
  always_comb begin
    accNext = acc - (acc >> AVG_SHIFT);
    if (clampActive) begin
      accNext = accNext + ACC_W'(FULL);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else if (strobe.clearAll) begin
      acc <= '0;
    end else begin
      acc <= accNext;
    end
  end

  assign clampOver = (acc[ACC_W-1:AVG_SHIFT] > AVG_W'(LIMIT));

  assert_long_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLong |=> timer == TMR_W'(LONG_TICKS));

  assert_short_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadShort && !strobe.loadLong && !strobe.clearAll) |=> timer == TMR_W'(SHORT_TICKS));

  assert_avg_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    acc <= ACC_W'(ACC_MAX));

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (timer == '0 && acc == '0));

endmodule

// File: rtl/fsup_control.sv
module fsup_control
  import fsup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       vddAboveOn,
  input  logic       vddAboveOff,
  input  logic       dieAboveTrip,
  input  logic       dieBelowRelease,
  input  logic       ocpTrip,
  input  logic       ovpTrip,
  input  logic       olpTrip,
  input  logic       switchOverpower,
  input  logic       timerIdle,
  input  logic       clampOver,
  output dpStrobe_t  strobe,
  output logic       convEnable,
  output logic       clampEnable,
  output logic [2:0] faultCode
);

  logic        powered;
  logic        thermalHot;
  logic        latched;
  retryClass_t activeClass;
  logic        shortEvt;
  logic        longEvt;
  logic        waitLong;

  // supply hysteresis: off point wins over on point
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      powered <= 1'b0;
    end else if (!vddAboveOff) begin
      powered <= 1'b0;
    end else if (vddAboveOn) begin
      powered <= 1'b1;
    end
  end

  // die temperature hysteresis
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thermalHot <= 1'b0;
    end else if (dieAboveTrip) begin
      thermalHot <= 1'b1;
    end else if (dieBelowRelease) begin
      thermalHot <= 1'b0;
    end
  end

  // clamp overpower latch, released only by supply loss
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latched <= 1'b0;
    end else if (!powered) begin
      latched <= 1'b0;
    end else if (clampOver) begin
      latched <= 1'b1;
    end
  end

  assign shortEvt = powered & (ocpTrip | ovpTrip | olpTrip);
  assign longEvt  = powered & switchOverpower;
  assign waitLong = (activeClass == CLS_LONG) & ~timerIdle;

  always_comb begin
    strobe.clearAll  = ~powered;
    strobe.loadLong  = longEvt | (shortEvt & waitLong);
    strobe.loadShort = shortEvt & ~strobe.loadLong;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeClass <= CLS_NONE;
    end else if (!powered) begin
      activeClass <= CLS_NONE;
    end else if (strobe.loadLong) begin
      activeClass <= CLS_LONG;
    end else if (strobe.loadShort) begin
      activeClass <= CLS_SHORT;
    end
  end

  always_comb begin
    if (!powered) begin
      faultCode = CODE_UNPOWER;
    end else if (latched) begin
      faultCode = CODE_LATCH;
    end else if (!timerIdle && activeClass == CLS_LONG) begin
      faultCode = CODE_LONG;
    end else if (!timerIdle) begin
      faultCode = CODE_SHORT;
    end else if (thermalHot) begin
      faultCode = CODE_THERMAL;
    end else begin
      faultCode = CODE_NONE;
    end
  end

  assign clampEnable = powered & ~latched;
  assign convEnable  = powered & ~latched & ~thermalHot & timerIdle;

  assert_supply_drop_R1: assert property (@(posedge clk) disable iff (!rstN)
    !vddAboveOff |=> (faultCode == CODE_UNPOWER && !convEnable && !clampEnable));

  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (faultCode == CODE_LATCH && vddAboveOff) |=> faultCode == CODE_LATCH);

  assert_thermal_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    dieAboveTrip |=> !convEnable);

  assert_fast_fault_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    (powered && vddAboveOff && (ocpTrip || ovpTrip || olpTrip)) |=> !convEnable);

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int TICK_DIV    = 100000,
  parameter int SHORT_TICKS = 1000,
  parameter int LONG_TICKS  = 30000,
  parameter int AVG_W       = 8,
  parameter int AVG_SHIFT   = 8,
  parameter int LIMIT_PCT   = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vddAboveOn,
  input  logic       vddAboveOff,
  input  logic       dieAboveTrip,
  input  logic       dieBelowRelease,
  input  logic       ocpTrip,
  input  logic       ovpTrip,
  input  logic       olpTrip,
  input  logic       switchOverpower,
  input  logic       clampActive,
  output logic       convEnable,
  output logic       clampEnable,
  output logic [2:0] faultCode
);

  dpStrobe_t strobe;
  logic      timerIdle;
  logic      clampOver;

  fsup_control u_control (
    .clk             (clk),
    .rstN            (rstN),
    .vddAboveOn      (vddAboveOn),
    .vddAboveOff     (vddAboveOff),
    .dieAboveTrip    (dieAboveTrip),
    .dieBelowRelease (dieBelowRelease),
    .ocpTrip         (ocpTrip),
    .ovpTrip         (ovpTrip),
    .olpTrip         (olpTrip),
    .switchOverpower (switchOverpower),
    .timerIdle       (timerIdle),
    .clampOver       (clampOver),
    .strobe          (strobe),
    .convEnable      (convEnable),
    .clampEnable     (clampEnable),
    .faultCode       (faultCode)
  );

  fsup_datapath #(
    .TICK_DIV    (TICK_DIV),
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_TICKS  (LONG_TICKS),
    .AVG_W       (AVG_W),
    .AVG_SHIFT   (AVG_SHIFT),
    .LIMIT_PCT   (LIMIT_PCT)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .clampActive (clampActive),
    .timerIdle   (timerIdle),
    .clampOver   (clampOver)
  );

endmodule

// File: tb/fault_supervisor_tb.sv
module fault_supervisor_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       vddAboveOn = 1'b0;
  logic       vddAboveOff = 1'b0;
  logic       dieAboveTrip = 1'b0;
  logic       dieBelowRelease = 1'b0;
  logic       ocpTrip = 1'b0;
  logic       ovpTrip = 1'b0;
  logic       olpTrip = 1'b0;
  logic       switchOverpower = 1'b0;
  logic       clampActive = 1'b0;
  logic       convEnable;
  logic       clampEnable;
  logic [2:0] faultCode;

  // 200 MHz
  always #2.5 clk = ~clk;

  fault_supervisor #(
    .TICK_DIV    (4),
    .SHORT_TICKS (10),
    .LONG_TICKS  (30)
  ) u_dut (
    .clk             (clk),
    .rstN            (rstN),
    .vddAboveOn      (vddAboveOn),
    .vddAboveOff     (vddAboveOff),
    .dieAboveTrip    (dieAboveTrip),
    .dieBelowRelease (dieBelowRelease),
    .ocpTrip         (ocpTrip),
    .ovpTrip         (ovpTrip),
    .olpTrip         (olpTrip),
    .switchOverpower (switchOverpower),
    .clampActive     (clampActive),
    .convEnable      (convEnable),
    .clampEnable     (clampEnable),
    .faultCode       (faultCode)
  );

  typedef struct {
    logic       en;
    logic       cen;
    logic [2:0] code;
    string      tag;
  } expItem_t;

  expItem_t sb[$];
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  task automatic expectOut(input logic en, input logic cen, input logic [2:0] code, input string tag);
    expItem_t it;
    it.en = en; it.cen = cen; it.code = code; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares outputs shortly after each expectation is queued
  initial begin
    forever begin
      expItem_t it;
      wait (sb.size() != 0);
      #1;
      it = sb.pop_front();
      nChecks++;
      if (convEnable !== it.en || clampEnable !== it.cen || faultCode !== it.code) begin
        nFails++;
        $display("FAIL %s: actual en=%0b clampEn=%0b code=%0d expected en=%0b clampEn=%0b code=%0d",
                 it.tag, convEnable, clampEnable, faultCode, it.en, it.cen, it.code);
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    step(3);
    expectOut(0, 0, 3'd1, "R1 reset state");
    rstN = 1'b1;
    vddAboveOff = 1'b1;
    step(2);
    expectOut(0, 0, 3'd1, "R1 below turn-on point");
    vddAboveOn = 1'b1;
    step(1);
    expectOut(1, 1, 3'd0, "R1 turn-on");
    vddAboveOn = 1'b0;
    step(5);
    expectOut(1, 1, 3'd0, "R1 hysteresis hold");

    // R3 overcurrent, short wait of 40 cycles
    ocpTrip = 1'b1; step(1); ocpTrip = 1'b0;
    expectOut(0, 1, 3'd3, "R3 ocp disables");
    step(37);
    expectOut(0, 1, 3'd3, "R3 ocp still waiting");
    step(4);
    expectOut(1, 1, 3'd0, "R3 ocp retry");

    ovpTrip = 1'b1; step(1); ovpTrip = 1'b0;
    expectOut(0, 1, 3'd3, "R3 ovp disables");
    step(41);
    expectOut(1, 1, 3'd0, "R3 ovp retry");

    olpTrip = 1'b1; step(1); olpTrip = 1'b0;
    expectOut(0, 1, 3'd3, "R3 olp disables");
    step(41);
    expectOut(1, 1, 3'd0, "R3 olp retry");

    // R4 overpower, long wait of 120 cycles
    switchOverpower = 1'b1; step(1); switchOverpower = 1'b0;
    expectOut(0, 1, 3'd4, "R4 overpower disables");
    step(117);
    expectOut(0, 1, 3'd4, "R4 still waiting");
    step(4);
    expectOut(1, 1, 3'd0, "R4 retry");

    // R5 repeated short fault restarts the wait
    ocpTrip = 1'b1; step(1); ocpTrip = 1'b0;
    step(19);
    ovpTrip = 1'b1; step(1); ovpTrip = 1'b0;
    step(37);
    expectOut(0, 1, 3'd3, "R5 restarted short wait");
    step(4);
    expectOut(1, 1, 3'd0, "R5 restarted short retry");

    // R5 short fault during long wait restarts the long wait
    switchOverpower = 1'b1; step(1); switchOverpower = 1'b0;
    step(49);
    ocpTrip = 1'b1; step(1); ocpTrip = 1'b0;
    expectOut(0, 1, 3'd4, "R9 long outranks short");
    step(117);
    expectOut(0, 1, 3'd4, "R5 long wait restarted");
    step(4);
    expectOut(1, 1, 3'd0, "R5 long retry after restart");

    // R8 thermal hysteresis
    dieAboveTrip = 1'b1; step(1); dieAboveTrip = 1'b0;
    expectOut(0, 1, 3'd2, "R8 thermal trip");
    step(5);
    expectOut(0, 1, 3'd2, "R8 thermal hold above release");
    dieBelowRelease = 1'b1; step(1); dieBelowRelease = 1'b0;
    expectOut(1, 1, 3'd0, "R8 thermal release");

    // R9 short outranks thermal
    dieAboveTrip = 1'b1; ocpTrip = 1'b1; step(1); ocpTrip = 1'b0; dieAboveTrip = 1'b0;
    expectOut(0, 1, 3'd3, "R9 short outranks thermal");
    step(45);
    expectOut(0, 1, 3'd2, "R9 thermal after short wait");
    dieBelowRelease = 1'b1; step(1); dieBelowRelease = 1'b0;
    expectOut(1, 1, 3'd0, "R8 release after combined");

    // R7 low-duty clamp activity does not latch
    for (int i = 0; i < 150; i++) begin
      clampActive = 1'b1; step(1); clampActive = 1'b0; step(19);
    end
    expectOut(1, 1, 3'd0, "R7 5 percent duty");
    for (int i = 0; i < 200; i++) begin
      clampActive = 1'b1; step(1); clampActive = 1'b0; step(11);
    end
    expectOut(1, 1, 3'd0, "R7 8 percent duty");

    // R6 high-duty clamp activity latches
    for (int i = 0; i < 200; i++) begin
      clampActive = 1'b1; step(1); clampActive = 1'b0; step(4);
    end
    expectOut(0, 0, 3'd5, "R6 20 percent duty latches");
    switchOverpower = 1'b1; step(1); switchOverpower = 1'b0;
    expectOut(0, 0, 3'd5, "R9 latch outranks long");
    step(200);
    expectOut(0, 0, 3'd5, "R6 latch holds");

    // R2 supply cycle clears latch and waits
    vddAboveOff = 1'b0; step(1);
    expectOut(0, 0, 3'd1, "R2 supply loss");
    vddAboveOff = 1'b1; step(2);
    expectOut(0, 0, 3'd1, "R1 waiting for turn-on");
    vddAboveOn = 1'b1; step(1); vddAboveOn = 1'b0;
    expectOut(1, 1, 3'd0, "R2 latch cleared");

    switchOverpower = 1'b1; step(1); switchOverpower = 1'b0;
    expectOut(0, 1, 3'd4, "R4 wait before supply cycle");
    vddAboveOff = 1'b0; step(1);
    vddAboveOff = 1'b1; vddAboveOn = 1'b1; step(1); vddAboveOn = 1'b0;
    expectOut(1, 1, 3'd0, "R2 wait cleared by supply cycle");

    step(2);
    wait (sb.size() == 0);
    #2;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule